// File: doc/BRIEF.md
# Peripheral Register Unit with Serial-Port Status and Interrupt Vector

This block sits beside a small processor core on the same clock. It decodes an I/O address bus with separate read and write strobes. Read data comes from a purely combinational multiplexer, so a read completes in the same cycle the address is presented. A write lands on the rising edge while the write strobe is high. The block holds two interrupt-enable bits, a segment-display output register and an LED toggle bit. It also returns the state of a bank of DIP switches.

The block stands in front of a fixed-format serial port. It builds that port's control, status and format words from the live ready and busy flags and from the enable bits. It forwards the received byte. It produces one-cycle read and write pulses toward the port's data register. A 6-bit interrupt vector is registered here. Its top bit marks a pending request, and receive requests take priority over transmit requests. Once a vector is loaded it is not replaced while the pending bit is set. Any address with no register behind it reads back a fixed recognisable pattern, which helps when debugging software.

Top module: `periph_regs`

## Requirements
- R1: While `clr` is high at a rising edge, the two interrupt enables, the segment output, the LED bit and the interrupt vector all go to zero.
- R2: A read of any address other than 0x2A, 0x2B, 0x2C, 0x36 and 0x40 returns 0xAA in the same cycle. Write-only addresses such as 0x38, 0x41 and 0x43 are included.
- R3: Address 0x36 reads back the switch inputs unchanged, in the same cycle.
- R4: A write to 0x38 loads `wdata[6:0]` into `seg` and inverts `led` at that edge. No other access changes `seg` or `led`.
- R5: A write to 0x43 sets the receive enable from `wdata[0]` and the transmit enable from `wdata[1]`. No other access changes them.
- R6: Address 0x2A reads as {rx enable, tx enable, tx enable, 1, 1, 0, 0, 0}, MSB first.
- R7: Address 0x2B reads as {`rx_ready`, not `tx_busy`, not `tx_busy`, 0, 0, 0, 0, 0}, MSB first. Address 0x40 reads as the constant 0x8E. Address 0x2C reads as `rx_byte`.
- R8: `uart_wr` equals `wr_stb` and `uart_rd` equals `rd_stb` when the address is 0x2C. Both are 0 at every other address. Both are combinational and last one cycle.
- R9: At each edge without `clr`, the vector takes one of three actions. If the receive enable is set and `rx_ready` is high, it loads 0x2B (6'b101011). Otherwise, if the transmit enable is set and `tx_busy` is low, it loads 0x2C (6'b101100). Otherwise it clears to 0.
- R10: While vector bit 5 is set and a request condition from R9 still holds, the vector keeps its value, even if the pending request has changed from one source to the other.
- R11: With both strobes high at 0x2C in one cycle, both `uart_wr` and `uart_rd` pulse in that cycle and `rdata` shows `rx_byte`.
- R12: With `wr_stb` low, the address and data on the bus change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared with the processor |
| clr | input | 1 | Synchronous clear, active high |
| addr | input | 8 | I/O register number |
| wdata | input | 8 | Write data |
| rd_stb | input | 1 | Read strobe |
| wr_stb | input | 1 | Write strobe |
| rdata | output | 8 | Read data, combinational |
| switches | input | 8 | DIP switch levels |
| seg | output | 7 | Segment display drive |
| led | output | 1 | LED bit, toggles on each segment write |
| rx_ready | input | 1 | Serial receiver holds a byte |
| rx_byte | input | 8 | Received byte |
| tx_busy | input | 1 | Serial transmitter is busy |
| uart_wr | output | 1 | Write pulse to the serial data register |
| uart_rd | output | 1 | Read pulse to the serial data register |
| irq_vec | output | 6 | Interrupt vector; bit 5 means pending |

## Verification
The hardest state to reach from the ports is a vector that is already pending for one source while only the other source's condition is still true. That is where the hold rule keeps a stale code instead of switching codes. The stimulus reaches it on purpose in a directed run: it enables both sources, raises `rx_ready` with the transmitter idle, then drops `rx_ready` and confirms that the receive code stays. Random cycles with biased ready and busy toggling then revisit that window many times against the bench's reference model.

// File: rtl/periph_regs_pkg.sv
package periph_regs_pkg;

   localparam int unsigned WORD_W = 8;

   localparam logic [7:0] ADR_SER_CTRL = 8'h2A;
   localparam logic [7:0] ADR_SER_STAT = 8'h2B;
   localparam logic [7:0] ADR_SER_DATA = 8'h2C;
   localparam logic [7:0] ADR_SWITCH   = 8'h36;
   localparam logic [7:0] ADR_SEGMENT  = 8'h38;
   localparam logic [7:0] ADR_SER_FMT  = 8'h40;
   localparam logic [7:0] ADR_IRQ_EN   = 8'h43;

   localparam logic [WORD_W-1:0] IDLE_WORD = 8'hAA;
   localparam logic [WORD_W-1:0] FMT_WORD  = 8'h8E;

   typedef struct packed {
      logic rx;
      logic tx;
   } irq_en_t;

   function automatic logic [WORD_W-1:0] ctrl_word(input irq_en_t en);
      return {en.rx, en.tx, en.tx, 5'b11000};
   endfunction

   function automatic logic [WORD_W-1:0] stat_word(input logic rdy, input logic busy);
      return {rdy, ~busy, ~busy, 5'b00000};
   endfunction

endpackage

// File: rtl/pr_ctrl_regs.sv
module pr_ctrl_regs
   import periph_regs_pkg::*;
#(
   parameter int unsigned          DATA_W  = 8,
   parameter int unsigned          ADDR_W  = 8,
   parameter int unsigned          SEG_W   = 7,
   parameter logic [ADDR_W-1:0]    A_SEG   = ADDR_W'(ADR_SEGMENT),
   parameter logic [ADDR_W-1:0]    A_IRQEN = ADDR_W'(ADR_IRQ_EN)
) (
   input  logic              clk,
   input  logic              clr,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   input  logic              wr_stb,
   output irq_en_t           en,
   output logic [SEG_W-1:0]  seg,
   output logic              led
);

   logic unused_hi;
   assign unused_hi = ^wdata[DATA_W-1:SEG_W];

   always_ff @(posedge clk) begin
      if (clr) begin
         en  <= '0;
         seg <= '0;
         led <= 1'b0;
      end else if (wr_stb) begin
         if (addr == A_SEG) begin
            seg <= wdata[SEG_W-1:0];
            led <= ~led;
         end
         if (addr == A_IRQEN) begin
            en.rx <= wdata[0];
            en.tx <= wdata[1];
         end
      end
   end

endmodule

// File: rtl/pr_irq_vec.sv
module pr_irq_vec #(
   parameter int unsigned VEC_W  = 6,
   parameter int unsigned RX_IDX = 11,
   parameter int unsigned TX_IDX = 12
) (
   input  logic             clk,
   input  logic             clr,
   input  logic             rx_en,
   input  logic             tx_en,
   input  logic             rx_ready,
   input  logic             tx_busy,
   output logic [VEC_W-1:0] vec
);

   localparam int unsigned     PEND    = VEC_W - 1;
   localparam logic [VEC_W-1:0] RX_LOAD = {1'b1, (VEC_W-1)'(RX_IDX)};
   localparam logic [VEC_W-1:0] TX_LOAD = {1'b1, (VEC_W-1)'(TX_IDX)};

   logic rx_req, tx_req;
   assign rx_req = rx_en & rx_ready;
   assign tx_req = tx_en & ~tx_busy;

   always_ff @(posedge clk) begin
      if (clr) begin
         vec <= '0;
      end else if (rx_req) begin
         if (!vec[PEND]) vec <= RX_LOAD;
      end else if (tx_req) begin
         if (!vec[PEND]) vec <= TX_LOAD;
      end else begin
         vec <= '0;
      end
   end

endmodule

// File: rtl/pr_read_mux.sv
module pr_read_mux
   import periph_regs_pkg::*;
#(
   parameter int unsigned       DATA_W = 8,
   parameter int unsigned       ADDR_W = 8,
   parameter logic [ADDR_W-1:0] A_CTRL = ADDR_W'(ADR_SER_CTRL),
   parameter logic [ADDR_W-1:0] A_STAT = ADDR_W'(ADR_SER_STAT),
   parameter logic [ADDR_W-1:0] A_DATA = ADDR_W'(ADR_SER_DATA),
   parameter logic [ADDR_W-1:0] A_SW   = ADDR_W'(ADR_SWITCH),
   parameter logic [ADDR_W-1:0] A_FMT  = ADDR_W'(ADR_SER_FMT)
) (
   input  logic              rd_stb,
   input  logic              wr_stb,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] switches,
   input  logic [DATA_W-1:0] rx_byte,
   input  logic              rx_ready,
   input  logic              tx_busy,
   input  irq_en_t           en,
   output logic [DATA_W-1:0] rdata,
   output logic              uart_rd,
   output logic              uart_wr
);

   logic [DATA_W-1:0] ctrl_w, stat_w, fmt_w, idle_w;

   if (DATA_W == WORD_W) begin : g_direct
      assign ctrl_w = ctrl_word(en);
      assign stat_w = stat_word(rx_ready, tx_busy);
      assign fmt_w  = FMT_WORD;
      assign idle_w = IDLE_WORD;
   end else begin : g_padded
      localparam int unsigned PAD = DATA_W - WORD_W;
      assign ctrl_w = {{PAD{1'b0}}, ctrl_word(en)};
      assign stat_w = {{PAD{1'b0}}, stat_word(rx_ready, tx_busy)};
      assign fmt_w  = {{PAD{1'b0}}, FMT_WORD};
      assign idle_w = {{PAD{1'b0}}, IDLE_WORD};
   end

   always_comb begin
      case (addr)
         A_CTRL:  rdata = ctrl_w;
         A_STAT:  rdata = stat_w;
         A_DATA:  rdata = rx_byte;
         A_SW:    rdata = switches;
         A_FMT:   rdata = fmt_w;
         default: rdata = idle_w;
      endcase
   end

   logic hit_data;
   assign hit_data = (addr == A_DATA);
   assign uart_rd  = rd_stb & hit_data;
   assign uart_wr  = wr_stb & hit_data;

endmodule

// File: rtl/periph_regs.sv
module periph_regs
   import periph_regs_pkg::*;
#(
   parameter int unsigned       DATA_W      = 8,
   parameter int unsigned       ADDR_W      = 8,
   parameter int unsigned       SEG_W       = 7,
   parameter int unsigned       VEC_W       = 6,
   parameter int unsigned       RX_VEC_IDX  = 11,
   parameter int unsigned       TX_VEC_IDX  = 12,
   parameter logic [ADDR_W-1:0] ADR_CTRL    = ADDR_W'(ADR_SER_CTRL),
   parameter logic [ADDR_W-1:0] ADR_STAT    = ADDR_W'(ADR_SER_STAT),
   parameter logic [ADDR_W-1:0] ADR_DATA    = ADDR_W'(ADR_SER_DATA),
   parameter logic [ADDR_W-1:0] ADR_SW      = ADDR_W'(ADR_SWITCH),
   parameter logic [ADDR_W-1:0] ADR_SEG     = ADDR_W'(ADR_SEGMENT),
   parameter logic [ADDR_W-1:0] ADR_FMT     = ADDR_W'(ADR_SER_FMT),
   parameter logic [ADDR_W-1:0] ADR_IRQ     = ADDR_W'(ADR_IRQ_EN)
) (
   input  logic              clk,
   input  logic              clr,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   input  logic              rd_stb,
   input  logic              wr_stb,
   output logic [DATA_W-1:0] rdata,
   input  logic [DATA_W-1:0] switches,
   output logic [SEG_W-1:0]  seg,
   output logic              led,
   input  logic              rx_ready,
   input  logic [DATA_W-1:0] rx_byte,
   input  logic              tx_busy,
   output logic              uart_wr,
   output logic              uart_rd,
   output logic [VEC_W-1:0]  irq_vec
);

   initial begin : param_chk
      assert (DATA_W >= WORD_W) else $fatal(1, "DATA_W below fixed word width");
      assert (ADDR_W >= 8)      else $fatal(1, "ADDR_W too narrow for register map");
      assert (SEG_W < DATA_W && SEG_W >= 2) else $fatal(1, "SEG_W out of range");
      assert (VEC_W >= 2)       else $fatal(1, "VEC_W too narrow");
      assert (RX_VEC_IDX < (1 << (VEC_W-1)) && TX_VEC_IDX < (1 << (VEC_W-1)))
         else $fatal(1, "vector index does not fit");
   end

   irq_en_t en;
   logic    rx_en, tx_en;
   assign rx_en = en.rx;
   assign tx_en = en.tx;

   pr_ctrl_regs #(
      .DATA_W(DATA_W), .ADDR_W(ADDR_W), .SEG_W(SEG_W),
      .A_SEG(ADR_SEG), .A_IRQEN(ADR_IRQ)
   ) u_ctrl (
      .clk(clk), .clr(clr), .addr(addr), .wdata(wdata), .wr_stb(wr_stb),
      .en(en), .seg(seg), .led(led)
   );

   pr_irq_vec #(
      .VEC_W(VEC_W), .RX_IDX(RX_VEC_IDX), .TX_IDX(TX_VEC_IDX)
   ) u_irq (
      .clk(clk), .clr(clr), .rx_en(rx_en), .tx_en(tx_en),
      .rx_ready(rx_ready), .tx_busy(tx_busy), .vec(irq_vec)
   );

   pr_read_mux #(
      .DATA_W(DATA_W), .ADDR_W(ADDR_W),
      .A_CTRL(ADR_CTRL), .A_STAT(ADR_STAT), .A_DATA(ADR_DATA),
      .A_SW(ADR_SW), .A_FMT(ADR_FMT)
   ) u_rmux (
      .rd_stb(rd_stb), .wr_stb(wr_stb), .addr(addr), .switches(switches),
      .rx_byte(rx_byte), .rx_ready(rx_ready), .tx_busy(tx_busy), .en(en),
      .rdata(rdata), .uart_rd(uart_rd), .uart_wr(uart_wr)
   );

endmodule

// File: rtl/periph_regs_chk.sv
module periph_regs_chk #(
   parameter int unsigned       ADDR_W = 8,
   parameter int unsigned       SEG_W  = 7,
   parameter int unsigned       VEC_W  = 6,
   parameter logic [ADDR_W-1:0] A_DATA = 8'h2C,
   parameter logic [ADDR_W-1:0] A_SEG  = 8'h38,
   parameter logic [ADDR_W-1:0] A_IRQ  = 8'h43,
   parameter logic [VEC_W-1:0]  RX_VEC = 6'b101011
) (
   input logic              clk,
   input logic              clr,
   input logic [ADDR_W-1:0] addr,
   input logic              rd_stb,
   input logic              wr_stb,
   input logic [SEG_W-1:0]  seg,
   input logic              led,
   input logic              rx_ready,
   input logic              tx_busy,
   input logic              rx_en,
   input logic              tx_en,
   input logic              uart_wr,
   input logic              uart_rd,
   input logic [VEC_W-1:0]  irq_vec
);

   localparam int unsigned PEND = VEC_W - 1;

   // R1
   clr_state_chk: assert property (@(posedge clk) disable iff (clr)
      $fell(clr) |-> (irq_vec == '0 && seg == '0 && !led && !rx_en && !tx_en));

   // R8
   uwr_gate_chk: assert property (@(posedge clk) disable iff (clr)
      uart_wr |-> (wr_stb && addr == A_DATA));

   // R8
   urd_gate_chk: assert property (@(posedge clk) disable iff (clr)
      uart_rd |-> (rd_stb && addr == A_DATA));

   // R4
   seg_hold_chk: assert property (@(posedge clk) disable iff (clr)
      !(wr_stb && addr == A_SEG) |=> ($stable(seg) && $stable(led)));

   // R4
   led_flip_chk: assert property (@(posedge clk) disable iff (clr)
      (wr_stb && addr == A_SEG) |=> (led != $past(led)));

   // R5
   en_hold_chk: assert property (@(posedge clk) disable iff (clr)
      !(wr_stb && addr == A_IRQ) |=> ($stable(rx_en) && $stable(tx_en)));

   // R9
   irq_idle_chk: assert property (@(posedge clk) disable iff (clr)
      !irq_vec[PEND] |-> (irq_vec == '0));

   // R9
   irq_rxpri_chk: assert property (@(posedge clk) disable iff (clr)
      (!irq_vec[PEND] && rx_en && rx_ready) |=> (irq_vec == RX_VEC));

   // R10
   irq_hold_chk: assert property (@(posedge clk) disable iff (clr)
      (irq_vec[PEND] && ((rx_en && rx_ready) || (tx_en && !tx_busy))) |=> $stable(irq_vec));

endmodule

bind periph_regs periph_regs_chk #(
   .ADDR_W(ADDR_W), .SEG_W(SEG_W), .VEC_W(VEC_W),
   .A_DATA(ADR_DATA), .A_SEG(ADR_SEG), .A_IRQ(ADR_IRQ),
   .RX_VEC({1'b1, (VEC_W-1)'(RX_VEC_IDX)})
) u_chk (
   .clk(clk), .clr(clr), .addr(addr), .rd_stb(rd_stb), .wr_stb(wr_stb),
   .seg(seg), .led(led), .rx_ready(rx_ready), .tx_busy(tx_busy),
   .rx_en(rx_en), .tx_en(tx_en), .uart_wr(uart_wr), .uart_rd(uart_rd),
   .irq_vec(irq_vec)
);

// File: tb/sim_periph_regs.sv
`timescale 1ns/1ps
module sim_periph_regs;

   logic       clk = 1'b0;
   logic       clr = 1'b1;
   logic [7:0] addr = '0, wdata = '0, switches = '0, rx_byte = '0;
   logic       rd_stb = 1'b0, wr_stb = 1'b0, rx_ready = 1'b0, tx_busy = 1'b1;
   logic [7:0] rdata;
   logic [6:0] seg;
   logic       led, uart_wr, uart_rd;
   logic [5:0] irq_vec;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   // reference state
   bit       m_rx_en, m_tx_en, m_led;
   bit [6:0] m_seg;
   bit [5:0] m_vec;

   always #5 clk = ~clk;

   periph_regs u0 (
      .clk(clk), .clr(clr), .addr(addr), .wdata(wdata), .rd_stb(rd_stb),
      .wr_stb(wr_stb), .rdata(rdata), .switches(switches), .seg(seg), .led(led),
      .rx_ready(rx_ready), .rx_byte(rx_byte), .tx_busy(tx_busy),
      .uart_wr(uart_wr), .uart_rd(uart_rd), .irq_vec(irq_vec)
   );

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic bit [7:0] exp_read(input bit [7:0] a);
      case (a)
         8'h2A:   return {m_rx_en, m_tx_en, m_tx_en, 5'b11000};   // R6
         8'h2B:   return {rx_ready, ~tx_busy, ~tx_busy, 5'b0};    // R7
         8'h2C:   return rx_byte;                                  // R7
         8'h36:   return switches;                                 // R3
         8'h40:   return 8'h8E;                                    // R7
         default: return 8'hAA;                                    // R2
      endcase
   endfunction

   function automatic string read_tag(input bit [7:0] a);
      case (a)
         8'h2A: return "R6";
         8'h2B, 8'h2C, 8'h40: return "R7";
         8'h36: return "R3";
         default: return "R2";
      endcase
   endfunction

   // called at the rising edge, before state is updated
   task automatic model_step();
      bit [5:0] nv;
      if (clr) begin
         m_vec = '0; m_rx_en = 0; m_tx_en = 0; m_seg = '0; m_led = 0;
         return;
      end
      nv = m_vec;
      if (m_rx_en && rx_ready) begin
         if (!m_vec[5]) nv = 6'b101011;
      end else if (m_tx_en && !tx_busy) begin
         if (!m_vec[5]) nv = 6'b101100;
      end else nv = '0;
      m_vec = nv;
      if (wr_stb && addr == 8'h38) begin m_seg = wdata[6:0]; m_led = ~m_led; end
      if (wr_stb && addr == 8'h43) begin m_rx_en = wdata[0]; m_tx_en = wdata[1]; end
   endtask

   // inputs already set just after a falling edge
   task automatic tick();
      #2;
      chk(rdata == exp_read(addr), read_tag(addr), rdata, exp_read(addr));
      chk(uart_wr == (wr_stb && addr == 8'h2C), "R8 wr", uart_wr, wr_stb && addr == 8'h2C);
      chk(uart_rd == (rd_stb && addr == 8'h2C), "R8 rd", uart_rd, rd_stb && addr == 8'h2C);
      @(posedge clk);
      model_step();
      @(negedge clk);
      chk(seg == m_seg, "R4 seg", seg, m_seg);
      chk(led == m_led, "R4 led", led, m_led);
      chk(irq_vec == m_vec, "R9_R10 vec", irq_vec, m_vec);
   endtask

   task automatic bus(input bit [7:0] a, input bit [7:0] d, input bit rd, input bit wr);
      addr = a; wdata = d; rd_stb = rd; wr_stb = wr;
      tick();
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      if (!done) begin
         checks++; failures++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin : main
      void'($urandom(32'd20240611));
      @(negedge clk);
      clr = 1'b1;
      repeat (3) tick();
      clr = 1'b0;
      // R1: reset state
      chk(seg == 7'd0 && !led && irq_vec == 6'd0, "R1", {seg, led, irq_vec}, 0);
      addr = 8'h2A; #1;
      chk(rdata == 8'h18, "R1 enables", rdata, 8'h18);

      // R2: unimplemented and write-only addresses
      foreach (u0.rdata[i]) begin end
      bus(8'h00, 8'h00, 1, 0); chk(rdata == 8'hAA, "R2", rdata, 8'hAA);
      bus(8'h43, 8'h00, 1, 0); chk(rdata == 8'hAA, "R2", rdata, 8'hAA);
      bus(8'h38, 8'h00, 1, 0); chk(rdata == 8'hAA, "R2", rdata, 8'hAA);
      bus(8'hFF, 8'h00, 1, 0); chk(rdata == 8'hAA, "R2", rdata, 8'hAA);

      // R3: switches
      switches = 8'h5C; addr = 8'h36; #1;
      chk(rdata == 8'h5C, "R3", rdata, 8'h5C);

      // R4: segment write
      bus(8'h38, 8'hFF, 0, 1);
      chk(seg == 7'h7F && led, "R4", {seg, led}, {7'h7F, 1'b1});
      // R12: strobe low, no change
      bus(8'h38, 8'h12, 0, 0);
      chk(seg == 7'h7F && led, "R12", {seg, led}, {7'h7F, 1'b1});
      bus(8'h43, 8'h03, 1, 0);
      addr = 8'h2A; #1;
      chk(rdata == 8'h18, "R12 enables", rdata, 8'h18);

      // R5 / R6: enables
      bus(8'h43, 8'h03, 0, 1);
      addr = 8'h2A; #1;
      chk(rdata == 8'hF8, "R5 R6", rdata, 8'hF8);
      bus(8'h43, 8'h02, 0, 1);
      addr = 8'h2A; #1;
      chk(rdata == 8'h78, "R5 R6", rdata, 8'h78);
      bus(8'h43, 8'h03, 0, 1);

      // R7: status, format, data
      rx_ready = 1'b1; tx_busy = 1'b1; rx_byte = 8'h3C; addr = 8'h2B; #1;
      chk(rdata == 8'h80, "R7 status", rdata, 8'h80);
      addr = 8'h40; #1; chk(rdata == 8'h8E, "R7 format", rdata, 8'h8E);
      addr = 8'h2C; #1; chk(rdata == 8'h3C, "R7 data", rdata, 8'h3C);

      // R9 / R10: interrupt priority and hold
      rx_ready = 1'b1; tx_busy = 1'b0;
      bus(8'h00, 8'h00, 0, 0);
      chk(irq_vec == 6'b101011, "R9 rx", irq_vec, 6'b101011);
      rx_ready = 1'b0;
      bus(8'h00, 8'h00, 0, 0);
      chk(irq_vec == 6'b101011, "R10 hold", irq_vec, 6'b101011);
      tx_busy = 1'b1;
      bus(8'h00, 8'h00, 0, 0);
      chk(irq_vec == 6'b000000, "R9 clear", irq_vec, 6'b000000);
      tx_busy = 1'b0;
      bus(8'h00, 8'h00, 0, 0);
      chk(irq_vec == 6'b101100, "R9 tx", irq_vec, 6'b101100);

      // R11: both strobes on the data register
      rx_byte = 8'hC3; addr = 8'h2C; rd_stb = 1; wr_stb = 1; #1;
      chk(uart_wr && uart_rd && rdata == 8'hC3, "R11", {uart_wr, uart_rd, rdata}, {2'b11, 8'hC3});
      tick();

      // R8: strobes away from data register
      addr = 8'h2D; rd_stb = 1; wr_stb = 1; #1;
      chk(!uart_wr && !uart_rd, "R8 off", {uart_wr, uart_rd}, 0);
      tick();

      // constrained random
      for (int n = 0; n < 4000; n++) begin
         int pick = $urandom_range(0, 11);
         case (pick)
            0: addr = 8'h2A;  1: addr = 8'h2B;  2: addr = 8'h2C;
            3: addr = 8'h36;  4: addr = 8'h38;  5: addr = 8'h40;
            6: addr = 8'h43;  7: addr = 8'h41;  8: addr = 8'h43;
            default: addr = 8'($urandom);
         endcase
         wdata    = 8'($urandom);
         rd_stb   = 1'($urandom);
         wr_stb   = ($urandom_range(0, 2) != 0);
         switches = 8'($urandom);
         rx_byte  = 8'($urandom);
         if ($urandom_range(0, 3) == 0) rx_ready = ~rx_ready;
         if ($urandom_range(0, 3) == 0) tx_busy  = ~tx_busy;
         clr      = ($urandom_range(0, 99) == 0);
         tick();
      end
      clr = 1'b0;

      done = 1'b1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule